// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write Controller

This block models the write path of a byte-wide parallel nonvolatile memory. The array sits in on-chip RAM. A fast system clock samples an active-low chip-select, output-enable and write-enable bus. Each accepted write strobe stores one byte in a page buffer. The buffer holds 32 bytes and is tagged by the page that the first stored byte selects.

A byte-load timer restarts after every accepted byte. If no further strobe begins before the timer runs out, a self-timed programming cycle copies the stored bytes into the array, then empties the buffer. A busy output shows the cycle. A host may also read the bus while the cycle runs: bit 7 returns the inverse of the last stored bit 7, and bit 6 changes from one read to the next, so the host can poll for the end of the cycle.

All delays are given in clock cycles, so a simulation can use short values. After reset, writes are refused for a set window. Strobes that are too short are dropped, and so are strobes that arrive while programming runs.

Top module: `eeprom_page_writer`

## Requirements
- R1: With ce_n=0, oe_n=0 and we_n=1 held, dout_en is 1 and dout carries the byte at addr two clock edges later. With ce_n=1, dout_en is 0.
- R2: A write strobe is the time during which ce_n=0, we_n=0 and oe_n=1. The address is taken where the strobe begins, which is the later of the two falling edges. The data is taken where it ends, which is the earlier rising edge. Either we_n or ce_n may shape the strobe.
- R3: A strobe that is active for fewer than GLITCH_CYC sampled cycles stores nothing and starts no programming.
- R4: Each accepted byte restarts a LOAD_TO-cycle timer, and the start of any new strobe stops it. When the timer expires, programming starts and rdy_busy_n goes low.
- R5: The upper ADDR_W-5 address bits of the first stored byte select the page, and the upper bits of later bytes are ignored. The low 5 bits select the byte within the page. A cycle writes only the 1 to 32 stored bytes and leaves the other bytes of the page unchanged.
- R6: Programming keeps rdy_busy_n low for PROG_CYC cycles, then releases it and empties the page buffer.
- R7: A read while programming runs returns the following:
  - bit 7 is the inverse of bit 7 of the last stored byte;
  - bit 6 is 0 on the first read of the cycle and flips after each completed read;
  - bits 5:0 are 0.
- R8: Strobes during programming are ignored. They change no array byte and start no second cycle.
- R9: For INIT_CYC cycles after reset, strobes are ignored.
- R10: Out of reset, rdy_busy_n is 1 and dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling status |
| dout_en | output | 1 | Read data is being driven |
| rdy_busy_n | output | 1 | 1 when ready, 0 while programming |

## Verification
Most internal faults in this block show up within one page commit:

- A timer that restarts, stops or counts wrongly moves the falling edge of rdy_busy_n. The edge then arrives earlier or later than LOAD_TO cycles after the last byte, or never arrives.
- A wrong byte-valid mask or page tag corrupts bytes that were never loaded. This shows on the first read after rdy_busy_n rises.
- Faults in the status path show during the first two or three reads in the busy window. Bit 7 or the alternation of bit 6 comes out wrong.

A full sweep over every page and byte of a small array makes any addressing error visible.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_W     = 5,
  parameter int GLITCH_CYC = 3,
  parameter int LOAD_TO    = 400,
  parameter int PROG_CYC   = 5000,
  parameter int INIT_CYC   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              rdy_busy_n
);
  localparam int NPG   = 1 << PAGE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SEL_W = ADDR_W - PAGE_W;
  localparam int LW    = $clog2(GLITCH_CYC + 1);
  localparam int TW    = $clog2(LOAD_TO + 1);
  localparam int PW    = $clog2(PROG_CYC);
  localparam int IW    = $clog2(INIT_CYC + 1);
  localparam logic [LW-1:0] GL     = LW'(GLITCH_CYC);
  localparam logic [TW-1:0] TO_L   = TW'(LOAD_TO);
  localparam logic [PW-1:0] PEND   = PW'(PROG_CYC - 1);
  localparam logic [IW-1:0] INIT_L = IW'(INIT_CYC);
  localparam logic [PW:0]   NPG_C  = (PW+1)'(NPG);

  logic              ce_q, oe_q, we_q;
  logic [ADDR_W-1:0] addr_q, a_lat;
  logic [7:0]        din_q, d_lat, rd_word;
  logic              wr_act, rd_act, wr_prev, rd_prev, wr_end, load_ok;
  logic [LW-1:0]     len;
  logic [IW-1:0]     init_cnt;
  logic              inhibit, busy, t_run, last7, tog;
  logic [TW-1:0]     timer;
  logic [PW-1:0]     prog_cnt;
  logic [SEL_W-1:0]  pg_sel;
  logic [NPG-1:0]    pg_valid;
  logic [7:0]        pg_data [NPG];
  logic [7:0]        mem [DEPTH];
  logic [PAGE_W-1:0] pidx;

  assign wr_act  = ~ce_q & ~we_q & oe_q;
  assign rd_act  = ~ce_q & ~oe_q & we_q;
  assign wr_end  = wr_prev & ~wr_act;
  assign inhibit = init_cnt != INIT_L;
  assign load_ok = wr_end & ~inhibit & ~busy & (len >= GL);
  assign pidx    = prog_cnt[PAGE_W-1:0];

  assign dout_en    = rd_act;
  assign dout       = busy ? {~last7, tog, 6'b0} : rd_word;
  assign rdy_busy_n = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ce_q, oe_q, we_q} <= 3'b111;
      addr_q   <= '0;
      din_q    <= '0;
      wr_prev  <= 1'b0;
      rd_prev  <= 1'b0;
      len      <= '0;
      a_lat    <= '0;
      d_lat    <= '0;
      init_cnt <= '0;
      busy     <= 1'b0;
      t_run    <= 1'b0;
      timer    <= '0;
      prog_cnt <= '0;
      pg_sel   <= '0;
      pg_valid <= '0;
      last7    <= 1'b0;
      tog      <= 1'b0;
    end else begin
      {ce_q, oe_q, we_q} <= {ce_n, oe_n, we_n};
      addr_q  <= addr;
      din_q   <= din;
      wr_prev <= wr_act;
      rd_prev <= rd_act;
      if (inhibit) init_cnt <= init_cnt + 1'b1;

      if (wr_act) begin
        d_lat <= din_q;
        if (!wr_prev) begin
          len   <= LW'(1);
          a_lat <= addr_q;
        end else if (len != GL) begin
          len <= len + 1'b1;
        end
      end

      if (wr_act && !wr_prev) begin
        t_run <= 1'b0;
      end else if (wr_end && !inhibit && !busy && (load_ok || pg_valid != '0)) begin
        t_run <= 1'b1;
        timer <= TO_L;
      end else if (t_run) begin
        if (timer == TW'(1)) begin
          t_run    <= 1'b0;
          busy     <= 1'b1;
          prog_cnt <= '0;
          tog      <= 1'b0;
        end else begin
          timer <= timer - 1'b1;
        end
      end

      if (load_ok) begin
        if (pg_valid == '0) pg_sel <= a_lat[ADDR_W-1:PAGE_W];
        pg_valid[a_lat[PAGE_W-1:0]] <= 1'b1;
        last7 <= d_lat[7];
      end

      if (busy) begin
        if (rd_prev && !rd_act) tog <= ~tog;
        if (prog_cnt == PEND) begin
          busy     <= 1'b0;
          pg_valid <= '0;
        end else begin
          prog_cnt <= prog_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load_ok) pg_data[a_lat[PAGE_W-1:0]] <= d_lat;
    if (busy && ({1'b0, prog_cnt} < NPG_C) && pg_valid[pidx])
      mem[{pg_sel, pidx}] <= pg_data[pidx];
    rd_word <= mem[addr_q];
  end
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int NPG = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ce_n,
  input logic           oe_n,
  input logic           we_n,
  input logic           dout_en,
  input logic           rdy_busy_n,
  input logic           inhibit,
  input logic           wr_act,
  input logic [NPG-1:0] pg_valid
);
  assert_read_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!$past(ce_n) && !$past(oe_n) && $past(we_n)));

  assert_start_outside_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_busy_n) |-> !$past(wr_act));

  assert_start_has_bytes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_busy_n) |-> (pg_valid != '0));

  assert_page_emptied_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_busy_n) |-> (pg_valid == '0));

  assert_frozen_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_busy_n && !$past(rdy_busy_n)) |-> $stable(pg_valid));

  assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (pg_valid == '0 && rdy_busy_n));
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(.NPG(NPG)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .dout_en(dout_en), .rdy_busy_n(rdy_busy_n), .inhibit(inhibit),
  .wr_act(wr_act), .pg_valid(pg_valid)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb_top;
  localparam int AW = 8, GC = 3, TO = 20, PC = 64, IC = 50;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en, rdy_busy_n;

  int checks = 0, failures = 0;
  int expv [DEPTH];
  bit done = 0;

  always #4 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .PAGE_W(5), .GLITCH_CYC(GC), .LOAD_TO(TO),
    .PROG_CYC(PC), .INIT_CYC(IC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .rdy_busy_n(rdy_busy_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int a, input int d, input int n, input bit ce_ctl);
    @(negedge clk);
    addr = AW'(a); din = 8'(d);
    if (ce_ctl) begin
      we_n = 0; @(negedge clk); ce_n = 0;
    end else begin
      ce_n = 0; we_n = 0;
    end
    repeat (n) @(negedge clk);
    if (ce_ctl) begin
      ce_n = 1; @(negedge clk); we_n = 1;
    end else begin
      we_n = 1; ce_n = 1;
    end
    @(negedge clk);
  endtask

  task automatic rd(input int a, output int v, output bit en);
    @(negedge clk);
    addr = AW'(a); ce_n = 0; oe_n = 0;
    repeat (3) @(negedge clk);
    v = int'(dout); en = dout_en;
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic commit(input string req);
    repeat (10) @(negedge clk);
    chk(rdy_busy_n == 1, req, rdy_busy_n, 1);
    repeat (TO - 6) @(negedge clk);
    chk(rdy_busy_n == 0, req, rdy_busy_n, 0);
    repeat (50) @(negedge clk);
    chk(rdy_busy_n == 0, "R6", rdy_busy_n, 0);
    repeat (18) @(negedge clk);
    chk(rdy_busy_n == 1, "R6", rdy_busy_n, 1);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v; bit en;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rdy_busy_n == 1, "R10", rdy_busy_n, 1);
    chk(dout_en == 0, "R10", dout_en, 0);

    // R9: write inside the power-up window is refused
    load(8'h10, 8'h55, 4, 0);
    repeat (30) @(negedge clk);
    chk(rdy_busy_n == 1, "R9", rdy_busy_n, 1);
    repeat (20) @(negedge clk);

    // R5/R6: sweep every page fully, then read everything back
    for (int p = 0; p < DEPTH / 32; p++) begin
      for (int b = 0; b < 32; b++) begin
        int a = p * 32 + b;
        expv[a] = (a * 37 + 11) & 255;
        load(a, expv[a], 4, 0);
      end
      commit("R4");
    end
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v, en);
      chk(v == expv[a] && en, "R5", v, expv[a]);
    end

    // R1: standby
    @(negedge clk); ce_n = 1; oe_n = 0;
    repeat (3) @(negedge clk);
    chk(dout_en == 0, "R1", dout_en, 0);
    oe_n = 1;

    // R3: short strobe stores nothing
    load(5, 8'hEE, 1, 0);
    repeat (30) @(negedge clk);
    chk(rdy_busy_n == 1, "R3", rdy_busy_n, 1);
    rd(5, v, en);
    chk(v == expv[5], "R3", v, expv[5]);

    // R2/R5: partial page 3, CE-controlled load, late address/data change, stray page bits
    load(8'h60, 8'hA5, 4, 0); expv[8'h60] = 8'hA5;
    load(8'h61, 8'h3C, 4, 1); expv[8'h61] = 8'h3C;
    @(negedge clk);
    addr = 8'h65; din = 8'h11; ce_n = 0; we_n = 0;
    @(negedge clk);
    addr = 8'h7F; din = 8'h81;
    repeat (3) @(negedge clk);
    we_n = 1; ce_n = 1;
    @(negedge clk);
    expv[8'h65] = 8'h81;
    load(8'h47, 8'h99, 4, 0); expv[8'h67] = 8'h99;
    commit("R4");
    for (int a = 8'h40; a < 8'h80; a++) begin
      rd(a, v, en);
      chk(v == expv[a], (a == 8'h65 || a == 8'h7F || a == 8'h61) ? "R2" : "R5", v, expv[a]);
    end

    // R4: loads spaced inside the timeout keep the timer from expiring
    for (int i = 0; i < 4; i++) begin
      load(8'hA0 + i, 8'h20 + i, 4, 0);
      expv[8'hA0 + i] = 8'h20 + i;
      if (i < 3) begin
        repeat (10) @(negedge clk);
        chk(rdy_busy_n == 1, "R4", rdy_busy_n, 1);
      end
    end
    commit("R4");
    for (int i = 0; i < 4; i++) begin
      rd(8'hA0 + i, v, en);
      chk(v == expv[8'hA0 + i], "R4", v, expv[8'hA0 + i]);
    end

    // R7/R8: polling during programming, strobe while busy ignored
    load(8'hC3, 8'h7A, 4, 0); expv[8'hC3] = 8'h7A;
    load(8'hC4, 8'hF0, 4, 0); expv[8'hC4] = 8'hF0;
    repeat (TO + 4) @(negedge clk);
    chk(rdy_busy_n == 0, "R4", rdy_busy_n, 0);
    rd(8'hC3, v, en); chk(v == 8'h00 && en, "R7", v, 8'h00);
    rd(8'hC3, v, en); chk(v == 8'h40 && en, "R7", v, 8'h40);
    rd(8'hC3, v, en); chk(v == 8'h00 && en, "R7", v, 8'h00);
    load(8'hD0, 8'h12, 4, 0);
    repeat (60) @(negedge clk);
    chk(rdy_busy_n == 1, "R6", rdy_busy_n, 1);
    repeat (30) @(negedge clk);
    chk(rdy_busy_n == 1, "R8", rdy_busy_n, 1);
    rd(8'hD0, v, en); chk(v == expv[8'hD0], "R8", v, expv[8'hD0]);
    rd(8'hC4, v, en); chk(v == 8'hF0, "R5", v, 8'hF0);
    rd(8'hC3, v, en); chk(v == 8'h7A, "R1", v, 8'h7A);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule